// File: doc/BRIEF.md
# Boot Sequencer with Status LED

This block is the top-level controller of a boot loader that streams a configuration image from serial flash into a programmable device. After the board powers up it holds its own reset for a programmable number of clock cycles. It then starts the flash reader and the configuration controller together, and waits for the configuration controller to report completion or failure. When either report arrives it tells the flash reader to stop, so the flash chip select is released.

One LED shows the overall state. The LED blinks while the boot is in progress. It stays on when configuration succeeded and stays off when configuration failed. The sequence runs once per power cycle and needs no outside command. The only way to run it again is a new assertion of `rst_ni`. Both the reset hold length and the blink half-period are parameters. The defaults are a 10 ms hold and a blink of about 1 Hz at an 80 MHz clock.

Top module: `boot_sequencer`

## Requirements
- R1: After `rst_ni` is released, the internal reset is held for exactly `RST_CYCLES` rising edges. No start is issued during that hold.
- R2: `rd_start_o` and `cfg_start_o` go high in the same cycle, for exactly one cycle, and only once per reset. This happens in the cycle after the hold ends, which is the cycle following rising edge `RST_CYCLES + 1`.
- R3: While loading, a high `cfg_error_i` leads to the failed state and a high `cfg_done_i` leads to the succeeded state. Each transition takes effect at the next edge. If both inputs are high together, the error wins.
- R4: `cfg_done_i` and `cfg_error_i` have no effect before loading has begun, that is, during the reset hold or during the start cycle.
- R5: The succeeded and failed states are terminal. Later pulses on either status input do not change the state, which persists until `rst_ni` is asserted again.
- R6: `rd_stop_o` is high in the succeeded and failed states and low in every other state, including while `rst_ni` is asserted.
- R7: The LED is on while `rst_ni` is low. From the release of `rst_ni` until a terminal state is reached, the LED inverts every `BLINK_HALF` edges, so after n edges it is on exactly when floor(n / `BLINK_HALF`) is even.
- R8: `led_o` is constantly 1 in the succeeded state and constantly 0 in the failed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| cfg_done_i | input | 1 | Configuration controller reports success |
| cfg_error_i | input | 1 | Configuration controller reports failure |
| rd_start_o | output | 1 | Single-cycle start to the flash reader |
| cfg_start_o | output | 1 | Single-cycle start to the configuration controller |
| rd_stop_o | output | 1 | Stop level to the flash reader (releases chip select) |
| led_o | output | 1 | Status LED drive, active high |

## Verification
Some properties are checked by assertions on every cycle:
- The hold flag stays set once it is set.
- The start strobe lasts one cycle and only follows a finished hold.
- The terminal states never change.
- The blink output can change only when its counter wraps.

Other behaviour can only be shown by the bench scenarios:
- The exact edge on which the starts fire.
- The priority of error over done.
- That status pulses sent before loading or after a terminal state are ignored.
- The exact phase of the LED pattern.

The bench shows these by sweeping the arrival cycle of each status kind against a model that counts edges.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_START   = 3'd1,
    ST_LOADING = 3'd2,
    ST_DONE    = 3'd3,
    ST_ERROR   = 3'd4
  } boot_state_e;
endpackage

// File: rtl/boot_por.sv
module boot_por #(
  parameter int unsigned RST_CYCLES = 800000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  // R1: hold release is sticky
  p_por_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  // R1: release only from the last count
  p_por_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/boot_blink.sv
module boot_blink #(
  parameter int unsigned BLINK_HALF = 40000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic blink_o
);
  localparam int unsigned CW = $clog2(BLINK_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          blink_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      blink_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      blink_q <= ~blink_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign blink_o = blink_q;

  // R7: phase changes only at counter wrap
  p_blink_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(blink_q));
  p_blink_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import boot_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_done_i,
  input  logic        cfg_done_i,
  input  logic        cfg_error_i,
  output logic        start_o,
  output logic        stop_o,
  output boot_state_e state_o
);
  boot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:   if (por_done_i) state_d = ST_START;
      ST_START:   state_d = ST_LOADING;
      ST_LOADING: begin
        if (cfg_error_i)     state_d = ST_ERROR;  // error has priority
        else if (cfg_done_i) state_d = ST_DONE;
      end
      ST_DONE:    state_d = ST_DONE;
      ST_ERROR:   state_d = ST_ERROR;
      default:    state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign start_o = (state_q == ST_START);
  assign stop_o  = (state_q == ST_DONE) || (state_q == ST_ERROR);
  assign state_o = state_q;

  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_after_por_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> por_done_i);
  p_done_terminal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_DONE));
  p_error_terminal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR) |=> (state_q == ST_ERROR));
  p_error_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOADING && cfg_error_i) |=> (state_q == ST_ERROR));
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 800000,
  parameter int unsigned BLINK_HALF = 40000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_done_i,
  input  logic cfg_error_i,
  output logic rd_start_o,
  output logic cfg_start_o,
  output logic rd_stop_o,
  output logic led_o
);
  logic        por_done;
  logic        blink;
  logic        start;
  logic        stop;
  boot_state_e state;

  boot_por #(.RST_CYCLES(RST_CYCLES)) u_por (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(por_done)
  );

  boot_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .blink_o(blink)
  );

  boot_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_done_i (por_done),
    .cfg_done_i (cfg_done_i),
    .cfg_error_i(cfg_error_i),
    .start_o    (start),
    .stop_o     (stop),
    .state_o    (state)
  );

  assign rd_start_o  = start;
  assign cfg_start_o = start;
  assign rd_stop_o   = stop;

  always_comb begin
    unique case (state)
      ST_DONE:  led_o = 1'b1;
      ST_ERROR: led_o = 1'b0;
      default:  led_o = blink;
    endcase
  end

  // R6: stop never overlaps a start
  p_stop_no_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stop_o |-> !rd_start_o);
endmodule

// File: tb/boot_sequencer_tb.sv
`timescale 1ns/1ps
module boot_sequencer_tb_top;
  localparam int RC = 12;
  localparam int BH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_done = 1'b0;
  logic cfg_error = 1'b0;
  logic rd_start, cfg_start, rd_stop, led;

  always #2 clk = ~clk;

  boot_sequencer #(.RST_CYCLES(RC), .BLINK_HALF(BH)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cfg_done_i (cfg_done),
    .cfg_error_i(cfg_error),
    .rd_start_o (rd_start),
    .cfg_start_o(cfg_start),
    .rd_stop_o  (rd_stop),
    .led_o      (led)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  // kind 0: done, 1: error, 2: both at once; d: loading cycles before status
  task automatic run_case(input int kind, input int d);
    int n;
    int st;
    int nst;
    int starts;
    logic exp_led;
    rst_ni = 1'b0; cfg_done = 1'b0; cfg_error = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "start in reset", rd_start, 1'b0);
    chk("R6", "stop in reset", rd_stop, 1'b0);
    chk("R7", "led in reset", led, 1'b1);
    rst_ni = 1'b1;
    n = 0; st = 0; starts = 0;
    for (int k = 0; k < RC + d + 20; k++) begin
      cfg_done = 1'b0; cfg_error = 1'b0;
      if (n == 3) cfg_done = 1'b1;            // R4: during hold
      if (n == 5) cfg_error = 1'b1;           // R4: during hold
      if (n == RC + 1) begin                  // R4: during start cycle
        cfg_error = 1'b1; cfg_done = 1'b1;
      end
      if (n == RC + 2 + d) begin              // R3
        cfg_done  = (kind != 1);
        cfg_error = (kind != 0);
      end
      if (n == RC + 5 + d) begin              // R5: late opposite pulse
        cfg_error = (kind == 0);
        cfg_done  = (kind != 0);
      end
      @(posedge clk);
      nst = st;
      case (st)
        0: if (n >= RC) nst = 1;
        1: nst = 2;
        2: if (cfg_error) nst = 4; else if (cfg_done) nst = 3;
        default: nst = st;
      endcase
      n++;
      st = nst;
      @(negedge clk);
      if (rd_start) starts++;
      chk(st == 1 ? "R2" : "R1", "rd_start", rd_start, st == 1);
      chk("R2", "cfg_start", cfg_start, st == 1);
      chk("R6", "rd_stop", rd_stop, st >= 3);
      if (st == 3)      exp_led = 1'b1;
      else if (st == 4) exp_led = 1'b0;
      else              exp_led = ((n / BH) % 2) == 0;
      chk(st >= 3 ? "R8" : "R7", "led", led, exp_led);
      if (n == RC + 1 + d + 8)
        chk(st >= 3 ? "R5" : "R3", "reached terminal", rd_stop, 1'b1);
    end
    checks++;
    if (starts != 1) begin
      errors++;
      $display("FAIL R2 start count: got %0d expected 1", starts);
    end
    if (kind == 2) chk("R3", "error wins led", led, 1'b0);
  endtask

  initial begin
    for (int kind = 0; kind < 3; kind++)
      for (int d = 0; d < 6; d++)
        run_case(kind, d);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule